// File: doc/BRIEF.md
# Frame-Alternating Color Depth Extender

This block feeds a display port that has a single bit per color channel and gives it more apparent color depth. Each pixel arrives as a six-bit color with two bits per channel. The block keeps a frame parity that flips once per vertical sync. For each channel it drives the first of that channel's two bits on even frames and the second on odd frames. The eye averages the two frames, so each channel shows off, half or full intensity. That gives 27 distinct colors. The cycle is fixed at two frames, because a longer cycle would flicker visibly.

The pixel stream is qualified by the active-video flag, which acts as its valid signal. There is no ready signal: a display cannot stall, so the source must present one pixel per pixel clock and no back-pressure is ever applied. Outside active video the outputs are held at zero. The three color outputs are registered, so the source must delay its sync signals by one clock to stay aligned with the color. The polarity of vertical sync is set by a parameter.

Top module: `vga_frame_dither`

## Requirements
- R1: While rst_n is low, red, green and blue are 0. After reset is released the frame parity is even, before any vertical sync assertion has been seen.
- R2: The color input is laid out as red = color[1:0], green = color[3:2] and blue = color[5:4]. On an even frame each output carries bit 0 of its channel's field.
- R3: On an odd frame each output carries bit 1 of its channel's field.
- R4: The frame parity toggles exactly once for each assertion of vsync, no matter how many clocks the pulse lasts. The assertion edge is detected synchronously on clk. vsync is asserted when it equals VSYNC_POL, and the default VSYNC_POL of 0 means active low.
- R5: A pixel sampled while active is 0 gives 0 on all three outputs, whatever its color value.
- R6: An output changes on the clk edge that samples the pixel, and so appears one cycle after the pixel is presented. It holds until the next edge.
- R7: Take a channel code presented in active video over one even frame and the following odd frame. The number of frames in which that channel is high equals the number of ones in its code: 00 gives 0, 01 and 10 give 1, and 11 gives 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync | input | 1 | Vertical sync, asserted when equal to VSYNC_POL |
| active | input | 1 | Active-video flag; qualifies the pixel as valid |
| color | input | 6 | Pixel color, two bits each for red [1:0], green [3:2] and blue [5:4] |
| red | output | 1 | Registered red output bit |
| green | output | 1 | Registered green output bit |
| blue | output | 1 | Registered blue output bit |

## Verification
The parity check assumes that vsync is a clean synchronous level that is sampled once per clock. The stimulus always changes it half a period away from the rising edge, and the pulses last several clocks. The output checks assume that a pixel is valid only while active is high. The stimulus keeps active low for the whole vsync pulse, so no pixel sampled in the cycle where the parity flips ever reaches the display. Colors are driven on the falling edge, so each one stays stable across the rising edge that samples it.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int NUM_CHAN = 3;
  localparam int CH_BITS  = 2;
  localparam int COLOR_W  = NUM_CHAN * CH_BITS;
  typedef logic [CH_BITS-1:0] chan_code_t;
endpackage

// File: rtl/vfd_frame_phase.sv
module vfd_frame_phase #(
  parameter logic VSYNC_POL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  output logic frame_odd
);
  logic vs_q;
  logic vs_hit;

  // one pulse on the first sampled cycle of an asserted sync
  assign vs_hit = (vsync == VSYNC_POL) && (vs_q != VSYNC_POL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= ~VSYNC_POL;
      frame_odd <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (vs_hit) frame_odd <= ~frame_odd;
    end
  end
endmodule

// File: rtl/vfd_chan_pick.sv
module vfd_chan_pick
  import vfd_pkg::*;
(
  input  chan_code_t code,
  input  logic       frame_odd,
  input  logic       active,
  output logic       pix
);
  always_comb begin
    pix = active & (frame_odd ? code[1] : code[0]);
  end
endmodule

// File: rtl/vfd_out_reg.sv
module vfd_out_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/vga_frame_dither.sv
module vga_frame_dither
  import vfd_pkg::*;
#(
  parameter logic VSYNC_POL = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               active,
  input  logic [COLOR_W-1:0] color,
  output logic               red,
  output logic               green,
  output logic               blue
);
  logic                frame_odd;
  logic [NUM_CHAN-1:0] pick_d;
  logic [NUM_CHAN-1:0] pick_q;

  vfd_frame_phase #(.VSYNC_POL(VSYNC_POL)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync    (vsync),
    .frame_odd(frame_odd)
  );

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    vfd_chan_pick u_pick (
      .code     (color[ch*CH_BITS +: CH_BITS]),
      .frame_odd(frame_odd),
      .active   (active),
      .pix      (pick_d[ch])
    );
  end

  vfd_out_reg #(.W(NUM_CHAN)) u_oreg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pick_d),
    .q    (pick_q)
  );

  assign red   = pick_q[0];
  assign green = pick_q[1];
  assign blue  = pick_q[2];
endmodule

// File: rtl/vfd_chk.sv
module vfd_chk #(
  parameter logic VSYNC_POL = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync,
  input logic       active,
  input logic [5:0] color,
  input logic       red,
  input logic       green,
  input logic       blue,
  input logic       frame_odd
);
  logic rst_seen;
  logic vs_prev;
  logic sync_start;

  always_ff @(posedge clk) rst_seen <= rst_seen | !rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev <= ~VSYNC_POL;
    else        vs_prev <= vsync;
  end

  assign sync_start = (vsync == VSYNC_POL) && (vs_prev != VSYNC_POL);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (rst_seen && !rst_n) |-> ({blue, green, red} == 3'b000 && !frame_odd));

  // R2
  even_low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_odd) |=> ({blue, green, red} == {$past(color[4]), $past(color[2]), $past(color[0])}));

  // R3
  odd_high_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frame_odd) |=> ({blue, green, red} == {$past(color[5]), $past(color[3]), $past(color[1])}));

  // R4
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> (frame_odd != $past(frame_odd)));

  // R4
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_start |=> $stable(frame_odd));

  // R5
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ({blue, green, red} == 3'b000));
endmodule

bind vga_frame_dither vfd_chk #(.VSYNC_POL(VSYNC_POL)) u_chk (.*);

// File: tb/vga_frame_dither_bench.sv
`timescale 1ns/1ps
module vga_frame_dither_bench;
  localparam logic VPOL = 1'b0;

  // {color[5:0], even {b,g,r}, odd {b,g,r}}
  localparam logic [11:0] TBL [8] = '{
    {6'b000000, 3'b000, 3'b000},
    {6'b111111, 3'b111, 3'b111},
    {6'b010101, 3'b111, 3'b000},
    {6'b101010, 3'b000, 3'b111},
    {6'b000001, 3'b001, 3'b000},
    {6'b000010, 3'b000, 3'b001},
    {6'b001100, 3'b010, 3'b010},
    {6'b100100, 3'b010, 3'b100}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = ~VPOL;
  logic       active = 1'b0;
  logic [5:0] color = '0;
  logic       red, green, blue;
  int         total = 0;
  int         bad = 0;
  int         cnt [64][3];

  always #4 clk = ~clk;

  vga_frame_dither #(.VSYNC_POL(VPOL)) u_vga_frame_dither (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .active(active),
    .color(color), .red(red), .green(green), .blue(blue)
  );

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // drive at current negedge, compare at the next one
  task automatic pix(input logic [5:0] c, input logic act, input logic [2:0] exp, input string tag);
    color  = c;
    active = act;
    @(negedge clk);
    chk(tag, {3'b000, blue, green, red}, {3'b000, exp});
  endtask

  task automatic vpulse(input int n);
    active = 1'b0;
    vsync  = VPOL;
    repeat (n) @(negedge clk);
    vsync  = ~VPOL;
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep_frame();
    for (int c = 0; c < 64; c++) begin
      color  = 6'(c);
      active = 1'b1;
      @(negedge clk);
      cnt[c][0] += int'(red);
      cnt[c][1] += int'(green);
      cnt[c][2] += int'(blue);
    end
    active = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep_pair();
    for (int c = 0; c < 64; c++)
      for (int k = 0; k < 3; k++) cnt[c][k] = 0;
    sweep_frame();
    vpulse(3);
    sweep_frame();
    for (int c = 0; c < 64; c++) begin
      logic [5:0] got, exp;
      got = {cnt[c][2][1:0], cnt[c][1][1:0], cnt[c][0][1:0]};
      exp = {2'($countones(c[5:4])), 2'($countones(c[3:2])), 2'($countones(c[1:0]))};
      chk("R7 two-frame level count per channel (R6 latency)", got, exp);
    end
  endtask

  initial begin
    #(8ns * 200000);
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", {3'b000, blue, green, red}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // even frame straight after reset
    foreach (TBL[i]) pix(TBL[i][11:6], 1'b1, TBL[i][5:3], "R2 even frame bit0 (R1 parity even)");
    vpulse(2);
    foreach (TBL[i]) pix(TBL[i][11:6], 1'b1, TBL[i][2:0], "R3 odd frame bit1");
    vpulse(2);

    // R6: output follows only after the sampling edge
    color = 6'b111111; active = 1'b1;
    #1 chk("R6 no change before edge", {3'b000, blue, green, red}, 6'b0);
    @(posedge clk); #1;
    chk("R6 change after one edge", {3'b000, blue, green, red}, 6'b000111);
    @(negedge clk);
    active = 1'b0;
    @(negedge clk);

    sweep_pair();
    vpulse(2);
    sweep_pair();
    vpulse(2);

    // R4: long pulse toggles only once (even -> odd)
    vpulse(12);
    pix(6'b000010, 1'b1, 3'b001, "R4 long vsync one toggle");
    pix(6'b000001, 1'b1, 3'b000, "R4 long vsync one toggle");
    // R4: deasserted vsync level changes nothing
    vsync = ~VPOL; repeat (5) @(negedge clk);
    pix(6'b100000, 1'b1, 3'b100, "R4 idle keeps parity");

    // R5: blanking forces zeros
    pix(6'b111111, 1'b0, 3'b000, "R5 blank with full color");
    pix(6'b101010, 1'b0, 3'b000, "R5 blank odd frame");

    // R1: reset while odd returns to even
    color = 6'b111111; active = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs low in reset mid-run", {3'b000, blue, green, red}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    pix(6'b000001, 1'b1, 3'b001, "R1 parity even after reset");
    pix(6'b010000, 1'b1, 3'b100, "R1 parity even after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule